// File: doc/BRIEF.md
# Segment Reference Protection Checker

This block decides whether a single memory reference may proceed through a cached segment. Each request presents the relevant descriptor fields, the reference itself (offset, size and access kind), the segment register that was named, the 64-bit linear address and a flag that selects 64-bit operation. One clock later the block answers. The answer is either a clean pass, a general protection fault on vector 13, or a separate segment-not-present indication on vector 11.

In legacy protected operation, the order of checks is fixed. The null-selector check comes first, then presence, then the byte limit (scaled by granularity), then the access rights implied by the segment type. In 64-bit operation, only the canonical form of the linear address is checked, plus the limit for the two thread-base segment registers. At most one fault is reported per request. A controller drives one request per cycle with `req_valid` and reads the verdict when `rsp_valid` pulses.

A two-state machine sequences each response. `ST_IDLE` means no verdict is pending. `ST_RESP` means a verdict from the previous cycle is on the outputs. The transition `IDLE->RESP` is taken on `req_valid`. `RESP->RESP` is taken on a back-to-back request. `RESP->IDLE` is taken when no request arrives. `IDLE->IDLE` holds otherwise.

Top module: `seg_access_checker`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `rsp_valid`, `fault` and `np_fault` are 0, and `vector` and `err_code` are 0.
- R2: A request sampled with `req_valid`=1 at a rising edge produces `rsp_valid`=1 for exactly the following cycle. A cycle with no request produces `rsp_valid`=0 in the following cycle.
- R3: The effective limit is the 20-bit `limit` when `gran`=0. It is `limit`*4096+4095 when `gran`=1, so a limit of 0xFFFFF reaches 0xFFFFFFFF.
- R4: The byte checked is the last one, `offset` + 2^`size_log2` − 1, computed without truncation. A reference that straddles the limit or wraps past 2^32 exceeds it.
- R5: A limit violation gives `fault`=1, `vector`=13, `err_code`=0.
- R6: `seg_type` bit 1 set means code and clear means data. Bit 0 means readable for code and writable for data. The access kinds are 0 read, 1 write, 2 execute, 3 push and 4 pop. Writes and pushes fault on code or on non-writable data. Execution faults on data. Reads and pops fault on code without the readable bit. Rights are checked only in legacy operation.
- R7: In legacy operation, a reference with `null_sel`=1 faults with vector 13 and error code 0.
- R8: A clear `present` bit in legacy operation gives `np_fault`=1 with `vector`=11 and never `fault`.
- R9: With `long_mode`=1, the limit is checked only for `seg_id` 4 and 5. Null, presence and rights are not checked.
- R10: With `long_mode`=1, a linear address whose bits 63:47 are not all equal gives `fault`, vector 13, error code 0. With `long_mode`=0, the address form has no effect.
- R11: Priority is null, then not-present, then canonical, then limit, then rights. `fault` and `np_fault` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| limit | input | 20 | Descriptor limit field |
| gran | input | 1 | Granularity: 0 bytes, 1 4-KB pages |
| present | input | 1 | Descriptor present bit |
| seg_type | input | 2 | {is_code, readable/writable} |
| null_sel | input | 1 | Segment register holds a null selector |
| offset | input | 32 | Effective offset of the first byte |
| size_log2 | input | 2 | Access size 1, 2, 4 or 8 bytes |
| acc_kind | input | 3 | Access kind code |
| long_mode | input | 1 | 64-bit operation |
| seg_id | input | 3 | 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| lin_addr | input | 64 | Linear address of the reference |
| rsp_valid | output | 1 | Verdict valid pulse |
| fault | output | 1 | Protection fault pulse |
| np_fault | output | 1 | Not-present indication pulse |
| vector | output | 8 | Exception vector when a fault is flagged |
| err_code | output | 32 | Error code, zero for every fault reported here |

## Verification
The hardest situation to reach is the one where several violations coincide. Examples are a null selector on a non-present segment, an over-limit write to a code segment, and a non-canonical address on an over-limit FS reference. Random stimulus seldom lines these up, so directed requests stack two faults at once and confirm that only the winning one appears. The other hard region is the exact limit boundary: byte offsets and multi-byte straddles within a few bytes of the scaled limit, and a carry past 2^32. To reach it, the random offsets are drawn around the effective limit rather than uniformly.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [2:0] {
        ACC_READ  = 3'd0,
        ACC_WRITE = 3'd1,
        ACC_EXEC  = 3'd2,
        ACC_PUSH  = 3'd3,
        ACC_POP   = 3'd4
    } acc_kind_e;

    localparam logic [2:0] SEG_FS = 3'd4;
    localparam logic [2:0] SEG_GS = 3'd5;

    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_NP = 8'd11;

    typedef struct packed {
        logic gp;
        logic np;
    } verdict_t;

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12
) (
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size_log2,
    output logic             over
);
    localparam int EFF_W = LIM_W + GRAN_SH;
    localparam int CMP_W = OFF_W + 1;

    logic [EFF_W-1:0] eff_lim;
    logic [CMP_W-1:0] eff_ext;
    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] span;

    always_comb begin
        if (gran) eff_lim = {limit, {GRAN_SH{1'b1}}};
        else      eff_lim = {{GRAN_SH{1'b0}}, limit};
        eff_ext   = {{(CMP_W-EFF_W){1'b0}}, eff_lim};
        span      = (CMP_W'(1) << size_log2) - CMP_W'(1);
        last_byte = {1'b0, offset} + span;
        over      = last_byte > eff_ext;
    end
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
    import seg_chk_pkg::*;
(
    input  logic [1:0] seg_type,
    input  logic [2:0] acc_kind,
    output logic       deny
);
    logic is_code;
    logic rw_bit;

    always_comb begin
        is_code = seg_type[1];
        rw_bit  = seg_type[0];
        unique case (acc_kind)
            ACC_WRITE, ACC_PUSH: deny = is_code | ~rw_bit;
            ACC_EXEC:            deny = ~is_code;
            default:             deny = is_code & ~rw_bit;
        endcase
    end
endmodule

// File: rtl/seg_canon_unit.sv
module seg_canon_unit #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48
) (
    input  logic [ADDR_W-1:0] lin_addr,
    output logic              noncanon
);
    logic [ADDR_W-1:0] sext;

    always_comb begin
        sext     = {{(ADDR_W-VA_BITS){lin_addr[VA_BITS-1]}}, lin_addr[VA_BITS-1:0]};
        noncanon = sext != lin_addr;
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12,
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48,
    parameter int ERR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LIM_W-1:0]  limit,
    input  logic              gran,
    input  logic              present,
    input  logic [1:0]        seg_type,
    input  logic              null_sel,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        size_log2,
    input  logic [2:0]        acc_kind,
    input  logic              long_mode,
    input  logic [2:0]        seg_id,
    input  logic [ADDR_W-1:0] lin_addr,
    output logic              rsp_valid,
    output logic              fault,
    output logic              np_fault,
    output logic [7:0]        vector,
    output logic [ERR_W-1:0]  err_code
);
    typedef enum logic {ST_IDLE, ST_RESP} state_e;

    state_e   state_q, state_d;
    verdict_t res_q, res_d;

    logic lim_over, rights_deny, noncanon, thread_seg;

    seg_limit_unit #(.OFF_W(OFF_W), .LIM_W(LIM_W), .GRAN_SH(GRAN_SH)) u_lim (
        .limit(limit), .gran(gran), .offset(offset),
        .size_log2(size_log2), .over(lim_over)
    );

    seg_rights_unit u_rights (
        .seg_type(seg_type), .acc_kind(acc_kind), .deny(rights_deny)
    );

    seg_canon_unit #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
        .lin_addr(lin_addr), .noncanon(noncanon)
    );

    // Priority chain: null, present, canonical, limit, rights
    always_comb begin
        thread_seg = (seg_id == SEG_FS) || (seg_id == SEG_GS);
        res_d      = '0;
        if (long_mode) begin
            if (noncanon)                    res_d.gp = 1'b1;
            else if (thread_seg && lim_over) res_d.gp = 1'b1;
        end else begin
            if (null_sel)         res_d.gp = 1'b1;
            else if (!present)    res_d.np = 1'b1;
            else if (lim_over)    res_d.gp = 1'b1;
            else if (rights_deny) res_d.gp = 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= req_valid ? res_d : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        fault     = 1'b0;
        np_fault  = 1'b0;
        vector    = '0;
        err_code  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                fault     = res_q.gp;
                np_fault  = res_q.np;
                if (res_q.gp)      vector = VEC_GP;
                else if (res_q.np) vector = VEC_NP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_access_checker_chk.sv
module seg_access_checker_chk #(
    parameter int ADDR_W  = 64,
    parameter int VA_BITS = 48,
    parameter int ERR_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              long_mode,
    input logic [ADDR_W-1:0] lin_addr,
    input logic              rsp_valid,
    input logic              fault,
    input logic              np_fault,
    input logic [7:0]        vector,
    input logic [ERR_W-1:0]  err_code
);
    logic addr_bad;
    assign addr_bad = !((lin_addr[ADDR_W-1:VA_BITS-1] == '0) ||
                        (lin_addr[ADDR_W-1:VA_BITS-1] == '1));

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R5
    gp_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (rsp_valid && vector == 8'd13 && err_code == '0));
    // R8
    np_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        np_fault |-> (rsp_valid && vector == 8'd11));
    // R11
    single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && np_fault));
    // R10
    noncanon_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode && addr_bad) |=> fault);
endmodule

bind seg_access_checker seg_access_checker_chk #(
    .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .long_mode(long_mode),
    .lin_addr(lin_addr), .rsp_valid(rsp_valid), .fault(fault),
    .np_fault(np_fault), .vector(vector), .err_code(err_code)
);

// File: tb/seg_access_checker_tb.sv
`timescale 1ns/1ps
module seg_access_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] limit = '0;
    logic        gran = 1'b0;
    logic        present = 1'b0;
    logic [1:0]  seg_type = '0;
    logic        null_sel = 1'b0;
    logic [31:0] offset = '0;
    logic [1:0]  size_log2 = '0;
    logic [2:0]  acc_kind = '0;
    logic        long_mode = 1'b0;
    logic [2:0]  seg_id = '0;
    logic [63:0] lin_addr = '0;
    logic        rsp_valid, fault, np_fault;
    logic [7:0]  vector;
    logic [31:0] err_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    due;
        bit    gp;
        bit    np;
        string tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seg_access_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .limit(limit),
        .gran(gran), .present(present), .seg_type(seg_type), .null_sel(null_sel),
        .offset(offset), .size_log2(size_log2), .acc_kind(acc_kind),
        .long_mode(long_mode), .seg_id(seg_id), .lin_addr(lin_addr),
        .rsp_valid(rsp_valid), .fault(fault), .np_fault(np_fault),
        .vector(vector), .err_code(err_code)
    );

    // Behavioural model written from the requirements
    function automatic void model(output bit gp, output bit np);
        longint unsigned eff, last;
        bit canon_ok, over, bad_rights, code, rw;
        eff  = gran ? (longint'(limit) * 4096 + 4095) : longint'(limit);
        last = longint'(offset) + (longint'(1) << size_log2) - 1;
        over = last > eff;
        canon_ok = (lin_addr[63:47] == 17'h0) || (lin_addr[63:47] == 17'h1FFFF);
        code = seg_type[1];
        rw   = seg_type[0];
        case (acc_kind)
            3'd1, 3'd3: bad_rights = code || !rw;
            3'd2:       bad_rights = !code;
            default:    bad_rights = code && !rw;
        endcase
        gp = 0; np = 0;
        if (long_mode) begin
            if (!canon_ok) gp = 1;
            else if ((seg_id == 3'd4 || seg_id == 3'd5) && over) gp = 1;
        end else if (null_sel) gp = 1;
        else if (!present) np = 1;
        else if (over) gp = 1;
        else if (bad_rights) gp = 1;
    endfunction

    task automatic send(input string tag);
        item_t it;
        bit g, n;
        req_valid = 1'b1;
        model(g, n);
        it.due = cyc + 1; it.gp = g; it.np = n; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic req(input string tag, input bit lm, input logic [2:0] sid,
                       input bit nul, input bit pr, input logic [1:0] ty,
                       input logic [2:0] kd, input bit g, input logic [19:0] lim,
                       input logic [31:0] off, input logic [1:0] sz,
                       input logic [63:0] la);
        @(negedge clk);
        long_mode = lm; seg_id = sid; null_sel = nul; present = pr; seg_type = ty;
        acc_kind = kd; gran = g; limit = lim; offset = off; size_log2 = sz;
        lin_addr = la;
        send(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                logic [7:0] ev;
                it = sb.pop_front();
                ev = it.gp ? 8'd13 : (it.np ? 8'd11 : 8'd0);
                checks++;
                if (rsp_valid !== 1'b1 || fault !== it.gp || np_fault !== it.np ||
                    ((it.gp || it.np) && vector !== ev) || err_code !== 32'd0) begin
                    errors++;
                    $display("FAIL %s: got v=%0b f=%0b np=%0b vec=%0d err=%0h exp v=1 f=%0b np=%0b vec=%0d err=0",
                             it.tag, rsp_valid, fault, np_fault, vector, err_code,
                             it.gp, it.np, ev);
                end
            end else if (cyc > 2) begin
                checks++;
                if (rsp_valid !== 1'b0) begin
                    errors++;
                    $display("FAIL R2 idle: got rsp_valid=%0b exp 0", rsp_valid);
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [63:0] CA = 64'h0000_0000_0000_1000;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || fault !== 0 || np_fault !== 0 || vector !== 0 || err_code !== 0) begin
            errors++;
            $display("FAIL R1 in reset: got %0b%0b%0b vec=%0d exp all zero", rsp_valid, fault, np_fault, vector);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || fault !== 0 || np_fault !== 0 || vector !== 0 || err_code !== 0) begin
            errors++;
            $display("FAIL R1 after reset: got %0b%0b%0b vec=%0d exp all zero", rsp_valid, fault, np_fault, vector);
        end
        // R3 byte granularity boundary
        req("R3 g0 at limit", 0, 3, 0, 1, 2'b01, 3'd0, 0, 20'hFFFF, 32'hFFFF, 0, CA);
        req("R3 R5 g0 past limit", 0, 3, 0, 1, 2'b01, 3'd0, 0, 20'hFFFF, 32'h10000, 0, CA);
        req("R3 g1 page end", 0, 3, 0, 1, 2'b01, 3'd0, 1, 20'h0, 32'hFFF, 0, CA);
        req("R3 g1 next page", 0, 3, 0, 1, 2'b01, 3'd0, 1, 20'h0, 32'h1000, 0, CA);
        req("R3 g1 full 4G", 0, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'hFFFFFFFF, 0, CA);
        idle();
        // R4 multi-byte
        req("R4 word fits", 0, 0, 0, 1, 2'b01, 3'd1, 0, 20'hFFFF, 32'hFFFE, 1, CA);
        req("R4 word straddles", 0, 0, 0, 1, 2'b01, 3'd1, 0, 20'hFFFF, 32'hFFFF, 1, CA);
        req("R4 qword wraps 4G", 0, 0, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'hFFFFFFFC, 3, CA);
        // R6 rights
        req("R6 write code", 0, 3, 0, 1, 2'b11, 3'd1, 1, 20'hFFFFF, 32'h10, 0, CA);
        req("R6 write ro data", 0, 3, 0, 1, 2'b00, 3'd1, 1, 20'hFFFFF, 32'h10, 0, CA);
        req("R6 exec data", 0, 1, 0, 1, 2'b01, 3'd2, 1, 20'hFFFFF, 32'h10, 0, CA);
        req("R6 read exec-only", 0, 3, 0, 1, 2'b10, 3'd0, 1, 20'hFFFFF, 32'h10, 0, CA);
        req("R6 read readable code", 0, 3, 0, 1, 2'b11, 3'd0, 1, 20'hFFFFF, 32'h10, 0, CA);
        req("R6 push ro data", 0, 2, 0, 1, 2'b00, 3'd3, 1, 20'hFFFFF, 32'h10, 2, CA);
        req("R6 pop ro data", 0, 2, 0, 1, 2'b00, 3'd4, 1, 20'hFFFFF, 32'h10, 2, CA);
        idle(); idle();
        // R7, R8, R11
        req("R7 null selector", 0, 3, 1, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, CA);
        req("R8 not present", 0, 3, 0, 0, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, CA);
        req("R8 np beats limit", 0, 3, 0, 0, 2'b01, 3'd0, 0, 20'h0, 32'h100, 0, CA);
        req("R11 null beats np", 0, 3, 1, 0, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, CA);
        req("R11 limit plus rights", 0, 3, 0, 1, 2'b11, 3'd1, 0, 20'h10, 32'h20, 0, CA);
        // R9 long mode
        req("R9 DS limit skipped", 1, 3, 0, 1, 2'b01, 3'd0, 0, 20'h10, 32'h100, 0, CA);
        req("R9 FS limit kept", 1, 4, 0, 1, 2'b01, 3'd0, 0, 20'h10, 32'h100, 0, CA);
        req("R9 GS limit kept", 1, 5, 0, 1, 2'b01, 3'd0, 0, 20'h10, 32'h100, 0, CA);
        req("R9 code write ignored", 1, 3, 1, 0, 2'b11, 3'd1, 0, 20'hFFFF, 32'h10, 0, CA);
        // R10 canonical edges
        req("R10 top low half", 1, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, 64'h0000_7FFF_FFFF_FFFF);
        req("R10 first hole", 1, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, 64'h0000_8000_0000_0000);
        req("R10 high half start", 1, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, 64'hFFFF_8000_0000_0000);
        req("R10 last hole", 1, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, 64'hFFFF_7FFF_FFFF_FFFF);
        req("R10 legacy ignores form", 0, 3, 0, 1, 2'b01, 3'd0, 1, 20'hFFFFF, 32'h0, 0, 64'h1234_0000_0000_0000);
        req("R10 canon beats FS limit", 1, 4, 0, 1, 2'b01, 3'd0, 0, 20'h0, 32'h100, 0, 64'h0001_0000_0000_0000);
        idle();
        // Random references clustered near the limit
        for (int i = 0; i < 600; i++) begin
            logic [31:0] eff;
            @(negedge clk);
            long_mode = ($urandom_range(0, 3) == 0);
            seg_id    = 3'($urandom_range(0, 5));
            null_sel  = ($urandom_range(0, 15) == 0);
            present   = ($urandom_range(0, 15) != 0);
            seg_type  = 2'($urandom);
            acc_kind  = 3'($urandom_range(0, 4));
            gran      = 1'($urandom);
            case ($urandom_range(0, 2))
                0: limit = 20'hFFFF;
                1: limit = 20'hFFFFF;
                default: limit = 20'($urandom);
            endcase
            eff = gran ? {limit, 12'hFFF} : {12'h0, limit};
            offset    = ($urandom_range(0, 3) == 0) ? $urandom : eff - 32'($urandom_range(0, 6)) + 32'($urandom_range(0, 3));
            size_log2 = 2'($urandom);
            case ($urandom_range(0, 3))
                0: lin_addr = {$urandom, $urandom};
                1: lin_addr = {17'h1FFFF, 15'($urandom), $urandom};
                default: lin_addr = {17'h0, 15'($urandom), $urandom};
            endcase
            if ($urandom_range(0, 4) == 0) req_valid = 1'b0;
            else send("R2 R3 R4 R6 R7 R8 R9 R10 R11 random");
        end
        idle(); idle(); idle();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule